// File: doc/BRIEF.md
# Interface Configuration Register Bank

A byte-wide register bank that sits behind a simple address/data bus with separate read and write strobes. It holds the interface configuration, read-only identification bytes, a status byte that reflects a converter-ready input, and one double-buffered configuration register. Software writes the pending copy of that register and later commits it to the active copy through a self-clearing transfer bit. The active copy drives `active_cfg_o` towards the rest of the chip.

Two self-clearing controls act on other state. A soft-reset bit in the first interface register pulses `soft_rst_o` for one cycle and clears both copies of the double-buffered register. The interface registers themselves are left intact. A readback-select bit chooses whether reads of the double-buffered address return the committed value or the pending value. Writes take effect at the clock edge that samples the strobe. Read data is registered and held until the next read.

Top module: `cfg_regbank`

## Requirements
- R1: After hardware reset (`rst_ni` low) every register holds its default: address 0x0000 reads 0x18, 0x0001 reads 0x00, 0x0100 reads 0x00 in either readback mode, `active_cfg_o` is 0x00 and `soft_rst_o` is 0.
- R2: Address 0x0000 always reads with bits 6:4 fixed at 0,0,1 and bit 7 at 0. Bits 3:0 are the reverse mirror of bits 4:7: bit 3 = bit 4, bit 2 = bit 5, bit 1 = bit 6, bit 0 = bit 7. Writes never change the value read.
- R3: A write to 0x0000 with bit 7 or its mirror bit 0 set drives `soft_rst_o` high for exactly one cycle, the cycle after the write edge. Writes with both bits clear do not pulse it.
- R4: A soft reset clears the pending and active copies of 0x0100, so `active_cfg_o` is 0x00 in the cycle after the write edge. It leaves 0x0000 and 0x0001 unchanged.
- R5: Address 0x0001 stores bit 5 only; its other bits read 0 regardless of writes.
- R6: A write to 0x0100 updates only the pending copy; `active_cfg_o` is unchanged.
- R7: Writing 0x000F with bit 0 = 1 copies the pending 0x0100 value into the active copy, visible on `active_cfg_o` the cycle after the write edge. 0x000F always reads 0x00, and a write with bit 0 = 0 has no effect.
- R8: A read of 0x0100 returns the active copy when 0x0001 bit 5 = 0 and the pending copy when it is 1.
- R9: Identification reads return fixed bytes: 0x0003=0x07, 0x0004=0x00, 0x0005=0x04, 0x0006=0x01, 0x000C=0x51, 0x000D=0x04. Writes to them are ignored.
- R10: Address 0x0103 reads 0 in bits 7:1 and the value of `conv_ready_i` at the read edge in bit 0.
- R11: Reads of any other address return 0x00, and writes to them change no readable state.
- R12: `rdata_o` is registered. It takes the addressed value at the edge that samples `rd_en_i` and holds it while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe |
| conv_ready_i | input | 1 | Converter-ready flag shown in the status byte |
| rdata_o | output | 8 | Registered read data |
| active_cfg_o | output | 8 | Active copy of the double-buffered register |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
Every result is due one edge after its stimulus. Register contents, `active_cfg_o` and `soft_rst_o` change at the edge that samples the write strobe. `rdata_o` changes at the edge that samples the read strobe. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a period after the edge that acts. The soft-reset pulse is sampled once more a full cycle later to show that it has already dropped. Random traffic across mapped, read-only and unmapped addresses is compared, read by read, against a bench model of the pending copy, active copy and readback select.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t A_IFA  = 16'h0000;
  localparam addr_t A_IFB  = 16'h0001;
  localparam addr_t A_TYPE = 16'h0003;
  localparam addr_t A_IDL  = 16'h0004;
  localparam addr_t A_IDH  = 16'h0005;
  localparam addr_t A_REV  = 16'h0006;
  localparam addr_t A_MFL  = 16'h000C;
  localparam addr_t A_MFH  = 16'h000D;
  localparam addr_t A_UPD  = 16'h000F;
  localparam addr_t A_CFG  = 16'h0100;
  localparam addr_t A_STAT = 16'h0103;

  localparam int SRST_BIT = 7;
  localparam int SRST_MIR = 0;
  localparam int SEL_BIT  = 5;
  localparam int UPD_BIT  = 0;

  // fixed upper nibble of 0x0000: soft reset reads 0, bits 6:4 = 0,0,1
  localparam logic [3:0] IFA_HI = 4'b0001;

  typedef struct packed {
    logic  hit;
    byte_t val;
  } id_t;

  function automatic id_t id_lookup(addr_t a);
    id_t r;
    r = '{hit: 1'b1, val: '0};
    unique case (a)
      A_TYPE:  r.val = 8'h07;
      A_IDL:   r.val = 8'h00;
      A_IDH:   r.val = 8'h04;
      A_REV:   r.val = 8'h01;
      A_MFL:   r.val = 8'h51;
      A_MFH:   r.val = 8'h04;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_regbank_pkg::*;
(
  input  logic  wr_en_i,
  input  addr_t addr_i,
  input  byte_t wdata_i,
  output logic  srst_req_o,
  output logic  sel_we_o,
  output logic  cfg_we_o,
  output logic  upd_req_o
);
  always_comb begin
    srst_req_o = 1'b0;
    sel_we_o   = 1'b0;
    cfg_we_o   = 1'b0;
    upd_req_o  = 1'b0;
    if (wr_en_i) begin
      unique case (addr_i)
        // soft reset accepted through bit 7 or its mirror
        A_IFA:   srst_req_o = wdata_i[SRST_BIT] | wdata_i[SRST_MIR];
        A_IFB:   sel_we_o   = 1'b1;
        A_CFG:   cfg_we_o   = 1'b1;
        A_UPD:   upd_req_o  = wdata_i[UPD_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dbuf.sv
module cfg_dbuf #(
  parameter int                W       = 8,
  parameter logic [W-1:0]      DEFAULT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  input  logic         rb_sel_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] rb_o
);
  logic [W-1:0] pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= DEFAULT;
      act_q  <= DEFAULT;
    end else if (clr_i) begin
      pend_q <= DEFAULT;
      act_q  <= DEFAULT;
    end else begin
      if (we_i)  pend_q <= wdata_i;
      if (upd_i) act_q  <= pend_q;
    end
  end

  assign act_o = act_q;
  assign rb_o  = rb_sel_i ? pend_q : act_q;

  a_r7_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i) |=> (act_o == $past(pend_q)));
  a_r6_pending_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> $stable(act_o));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (act_o == DEFAULT));
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_regbank_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_en_i,
  input  addr_t addr_i,
  input  logic  sel_i,
  input  byte_t cfg_rb_i,
  input  logic  ready_i,
  output byte_t rdata_o
);
  byte_t ifa_val, nxt, rdata_q;
  id_t   id;

  assign ifa_val[7:4] = IFA_HI;
  for (genvar i = 0; i < 4; i++) begin : g_mirror
    assign ifa_val[i] = ifa_val[7-i];
  end

  always_comb begin
    id  = id_lookup(addr_i);
    nxt = '0;
    if (id.hit) nxt = id.val;
    else begin
      unique case (addr_i)
        A_IFA:   nxt = ifa_val;
        A_IFB:   nxt[SEL_BIT] = sel_i;
        A_CFG:   nxt = cfg_rb_i;
        A_STAT:  nxt[0] = ready_i;
        default: nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= nxt;
  end

  assign rdata_o = rdata_q;

  a_r2_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_IFA) |=>
      (rdata_o[3] == rdata_o[4] && rdata_o[2] == rdata_o[5] &&
       rdata_o[1] == rdata_o[6] && rdata_o[0] == rdata_o[7]));
  a_r10_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_STAT) |=> (rdata_o == {7'b0, $past(ready_i)}));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter logic [7:0] CFG_DEFAULT = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic        conv_ready_i,
  output logic [7:0]  rdata_o,
  output logic [7:0]  active_cfg_o,
  output logic        soft_rst_o
);
  logic  srst_req, sel_we, cfg_we, upd_req;
  logic  sel_q, srst_q;
  byte_t cfg_rb;

  cfg_wr_decode u_dec (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .srst_req_o (srst_req),
    .sel_we_o   (sel_we),
    .cfg_we_o   (cfg_we),
    .upd_req_o  (upd_req)
  );

  // interface registers are outside soft reset scope
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (sel_we) sel_q <= wdata_i[SEL_BIT];
      srst_q <= srst_req;
    end
  end

  cfg_dbuf #(.W(DATA_W), .DEFAULT(CFG_DEFAULT)) u_dbuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (srst_req),
    .we_i     (cfg_we),
    .wdata_i  (wdata_i),
    .upd_i    (upd_req),
    .rb_sel_i (sel_q),
    .act_o    (active_cfg_o),
    .rb_o     (cfg_rb)
  );

  cfg_rd_mux u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .sel_i    (sel_q),
    .cfg_rb_i (cfg_rb),
    .ready_i  (conv_ready_i),
    .rdata_o  (rdata_o)
  );

  assign soft_rst_o = srst_q;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  a_r3_no_stray_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_IFA) |=> !soft_rst_o);
  a_r4_spares_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $stable(sel_q));
endmodule

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        conv_ready_i = 1'b0;
  logic [7:0]  rdata_o, active_cfg_o;
  logic        soft_rst_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic       m_sel;
  logic [7:0] m_pend, m_act;

  always #2 clk_i = ~clk_i;

  cfg_regbank u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [15:0] a, logic rdy);
    case (a)
      16'h0000: return 8'h18;
      16'h0001: return {2'b00, m_sel, 5'b0};
      16'h0003: return 8'h07;
      16'h0004: return 8'h00;
      16'h0005: return 8'h04;
      16'h0006: return 8'h01;
      16'h000C: return 8'h51;
      16'h000D: return 8'h04;
      16'h0100: return m_sel ? m_pend : m_act;
      16'h0103: return {7'b0, rdy};
      default:  return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(logic [15:0] a, logic [7:0] d);
    case (a)
      16'h0000: if (d[7] | d[0]) begin m_pend = 8'h00; m_act = 8'h00; end
      16'h0001: m_sel = d[5];
      16'h0100: m_pend = d;
      16'h000F: if (d[0]) m_act = m_pend;
      default: ;
    endcase
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic rd_chk(string req, logic [15:0] a);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp_rd(a, conv_ready_i));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] addrs [14] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004,
                                16'h0005, 16'h0006, 16'h000C, 16'h000D, 16'h000F,
                                16'h0100, 16'h0103, 16'h0200, 16'h7FFF};
    void'($urandom(32'd1234));
    m_sel = 0; m_pend = 0; m_act = 0;
    repeat (3) @(negedge clk_i);
    check("R1 soft_rst in reset", {7'b0, soft_rst_o}, 8'h00);
    rst_ni = 1'b1;
    check("R1 active default", active_cfg_o, 8'h00);
    rd_chk("R1 ifa default", 16'h0000);
    rd_chk("R1 ifb default", 16'h0001);
    rd_chk("R1 cfg default", 16'h0100);

    // R2: writes do not alter 0x0000
    wr(16'h0000, 8'h66);
    check("R3 no pulse with bits 7,0 clear", {7'b0, soft_rst_o}, 8'h00);
    rd_chk("R2 ifa after write", 16'h0000);

    // R5 / R6 / R8
    wr(16'h0001, 8'hFF);
    rd_chk("R5 ifb only bit5", 16'h0001);
    wr(16'h0100, 8'hA5);
    check("R6 active unchanged", active_cfg_o, 8'h00);
    rd_chk("R8 pending readback", 16'h0100);
    wr(16'h0001, 8'h00);
    rd_chk("R8 active readback", 16'h0100);

    // R7
    wr(16'h000F, 8'hFE);
    check("R7 bit0 clear no commit", active_cfg_o, 8'h00);
    @(negedge clk_i);
    addr_i = 16'h000F; wdata_i = 8'h01; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; model_wr(16'h000F, 8'h01);
    check("R7 commit next cycle", active_cfg_o, 8'hA5);
    rd_chk("R7 upd reads zero", 16'h000F);

    // R3 / R4 via mirror bit 0, sel set beforehand
    wr(16'h0001, 8'h20);
    wr(16'h0100, 8'h3C);
    @(negedge clk_i);
    addr_i = 16'h0000; wdata_i = 8'h01; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; model_wr(16'h0000, 8'h01);
    check("R3 pulse high", {7'b0, soft_rst_o}, 8'h01);
    check("R4 active cleared", active_cfg_o, 8'h00);
    @(negedge clk_i);
    check("R3 pulse one cycle", {7'b0, soft_rst_o}, 8'h00);
    rd_chk("R4 ifb kept", 16'h0001);
    rd_chk("R4 pending cleared", 16'h0100);
    rd_chk("R2 ifa after soft reset", 16'h0000);
    wr(16'h0000, 8'h80);
    rd_chk("R3 bit7 reads zero", 16'h0000);

    // R9 / R10 / R11
    for (int i = 0; i < 14; i++) wr(addrs[i] == 16'h0001 || addrs[i] == 16'h0100 ||
                                    addrs[i] == 16'h000F || addrs[i] == 16'h0000
                                    ? 16'h0002 : addrs[i], 8'hFF);
    rd_chk("R9 type", 16'h0003);
    rd_chk("R9 id lo", 16'h0004);
    rd_chk("R9 id hi", 16'h0005);
    rd_chk("R9 rev", 16'h0006);
    rd_chk("R9 mfr lo", 16'h000C);
    rd_chk("R9 mfr hi", 16'h000D);
    conv_ready_i = 1'b1;
    rd_chk("R10 ready high", 16'h0103);
    conv_ready_i = 1'b0;
    rd_chk("R10 ready low", 16'h0103);
    rd_chk("R11 unmapped 0x0002", 16'h0002);
    rd_chk("R11 unmapped 0x7FFF", 16'h7FFF);
    rd_chk("R11 pending untouched", 16'h0100);

    // R12: hold while no read
    rd(16'h000C, v);
    addr_i = 16'h0003;
    repeat (2) @(negedge clk_i);
    check("R12 hold", rdata_o, 8'h51);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = addrs[$urandom_range(13)];
      d = 8'($urandom);
      conv_ready_i = 1'($urandom);
      if ($urandom_range(1)) wr(a, d);
      else rd_chk("R8 random read", a);
      check("R7 random active", active_cfg_o, m_act);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule